// File: doc/BRIEF.md
# Page-Mode DRAM Cycle Sequencer

This block times each CPU memory cycle toward a DRAM-style store, counted in system ticks (one tick per clock). Every cycle is either a full cycle, which precharges and then raises the row strobe before the column strobe, or a shortened page cycle, which keeps the row strobe high and only pulses the column strobe. Page cycles are reserved for instruction-stream reads.

The choice of cycle type is made one cycle early and without an address comparator. When an instruction-stream fetch finishes, the opcode the CPU is executing is decoded. If it cannot redirect the program counter and the fetch was not on the last column of its page, the next sequential fetch must land in the same page, so the row is kept open. Video DMA, refresh or interrupt entry can take the memory in the meantime. Any of them closes the row, so a stale row is never reused. The sequencer also drives a multiplexed row/column address, a write strobe, a one-tick completion pulse and a flag that marks page cycles.

Top module: `page_cycle_seq`

## Requirements
- R1: While reset is held, and on leaving it, the row strobe, column strobe, write strobe, completion pulse and page flag are all low.
- R2: A request is taken when the sequencer is idle, or in the tick where the running cycle completes. A full cycle occupies 5 ticks after it is taken. The row strobe is low in tick 1 and high in ticks 2 to 5. The column strobe is high in ticks 3 and 4. The completion pulse is high in tick 5 only.
- R3: A page cycle occupies 4 ticks. The row strobe is high in all of them, the column strobe in ticks 2 and 3, and the completion pulse in tick 4 only. The page flag is high for all 4 ticks.
- R4: Writes and reads not flagged as instruction fetches always use full cycles. The row strobe is released when such a cycle ends.
- R5: An instruction fetch read uses a page cycle exactly when the previous cycle was an instruction fetch read that ended with the row held. The conditions for holding the row are given in R6, R7 and R8.
- R6: The row is not held after a fetch whose accompanying opcode byte can redirect the program counter. These are 0x00, 0x20, 0x40, 0x60, 0x4C, 0x6C, 0x7C, 0x80, and every byte whose low five bits are 10000b. All other byte values allow the row to be held.
- R7: The row is not held after a fetch whose address has every column bit set (the last column of a page).
- R8: The veto inputs are video busy, refresh busy and interrupt entry. A veto while idle drops the row strobe on the next tick. A veto in the tick where a request is taken makes that cycle a full cycle. A veto while a cycle runs makes the following fetch a full cycle.
- R9: When the row is held, the row strobe stays high through idle ticks and into the next page cycle.
- R10: The write strobe is high in every tick of a write cycle and low in every tick of a read cycle.
- R11: The memory address output carries the column (zero-extended) from the first column-strobe tick of a full cycle to its end, and in every tick of a page cycle. In the other ticks of a full cycle it carries the row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System tick clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | CPU requests a memory cycle; held until completion |
| req_addr_i | input | ADDR_W | Byte address of the access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_fetch_i | input | 1 | Access is an instruction-stream read |
| req_opcode_i | input | 8 | Opcode byte currently held by the CPU decoder |
| vid_busy_i | input | 1 | Video DMA is using the memory |
| rfsh_busy_i | input | 1 | Refresh is using the memory |
| irq_entry_i | input | 1 | CPU is entering an interrupt |
| ras_o | output | 1 | Row strobe, active high |
| cas_o | output | 1 | Column strobe, active high |
| we_o | output | 1 | Write strobe, active high |
| mem_addr_o | output | max(ADDR_W-PAGE_W, PAGE_W) | Multiplexed row/column address |
| done_o | output | 1 | One-tick pulse in the last tick of a cycle |
| page_cycle_o | output | 1 | Current cycle is a page cycle |

## Verification
The bench builds the sequencer with a 10-bit address and a 4-bit column, so a page has only 16 columns. This lets a short sweep put a fetch on every column, including the last one, and observe the page-crossing rule of R7. All 256 opcode byte values are swept through the fetch-then-fetch pattern to cover R6 completely. The strobe timings keep their default widths, so every cycle can be compared tick by tick against the fixed 5-tick and 4-tick shapes. Each veto input is applied in three places: while idle, in the tick a request is taken, and in the middle of a page cycle.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    // Width of the tick counter inside a cycle; cycles must fit in 2**PH_W ticks.
    localparam int PH_W = 4;

    // True when the opcode cannot redirect the program counter, so the next
    // instruction-stream read follows on from the current one.
    function automatic logic op_is_sequential(input logic [7:0] op);
        logic redirect;
        redirect = (op == 8'h00) || (op == 8'h20) || (op == 8'h40) ||
                   (op == 8'h60) || (op == 8'h4C) || (op == 8'h6C) ||
                   (op == 8'h7C) || (op == 8'h80) || (op[4:0] == 5'b10000);
        return !redirect;
    endfunction

endpackage

// File: rtl/pcs_predict.sv
module pcs_predict #(
    parameter int PAGE_W = 8
) (
    input  logic [7:0]        opcode_i,
    input  logic [PAGE_W-1:0] col_i,
    output logic              seq_o,
    output logic              col_last_o
);
    import pcs_pkg::*;

    assign seq_o      = op_is_sequential(opcode_i);
    assign col_last_o = &col_i;

endmodule

// File: rtl/pcs_strobe.sv
module pcs_strobe #(
    parameter int PRE_TICKS = 1,
    parameter int RCD_TICKS = 1,
    parameter int CAS_TICKS = 2
) (
    input  logic                     page_i,
    input  logic [pcs_pkg::PH_W-1:0] ph_i,
    output logic                     ras_o,
    output logic                     cas_o,
    output logic                     col_sel_o,
    output logic                     done_o
);
    import pcs_pkg::*;

    localparam int NLEN = PRE_TICKS + RCD_TICKS + CAS_TICKS + 1;
    localparam int PLEN = CAS_TICKS + 2;
    localparam int CAS0 = PRE_TICKS + RCD_TICKS;

    localparam logic [PH_W-1:0] N_RAS  = PH_W'(PRE_TICKS);
    localparam logic [PH_W-1:0] N_CAS0 = PH_W'(CAS0);
    localparam logic [PH_W-1:0] N_CAS1 = PH_W'(CAS0 + CAS_TICKS);
    localparam logic [PH_W-1:0] N_LAST = PH_W'(NLEN - 1);
    localparam logic [PH_W-1:0] P_CAS0 = PH_W'(1);
    localparam logic [PH_W-1:0] P_CAS1 = PH_W'(1 + CAS_TICKS);
    localparam logic [PH_W-1:0] P_LAST = PH_W'(PLEN - 1);

    logic n_ras, n_cas, n_col, n_done;
    logic p_cas, p_done;

    // Full cycle: precharge, row open, column window, closing tick.
    assign n_ras  = (ph_i >= N_RAS);
    assign n_col  = (ph_i >= N_CAS0);
    assign n_cas  = (ph_i >= N_CAS0) && (ph_i < N_CAS1);
    assign n_done = (ph_i == N_LAST);

    // Page cycle: row already open, column setup, column window, closing tick.
    assign p_cas  = (ph_i >= P_CAS0) && (ph_i < P_CAS1);
    assign p_done = (ph_i == P_LAST);

    always_comb begin
        if (page_i) begin
            ras_o     = 1'b1;
            col_sel_o = 1'b1;
            cas_o     = p_cas;
            done_o    = p_done;
        end else begin
            ras_o     = n_ras;
            col_sel_o = n_col;
            cas_o     = n_cas;
            done_o    = n_done;
        end
    end

endmodule

// File: rtl/page_cycle_seq.sv
module page_cycle_seq #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 8,
    parameter int PRE_TICKS = 1,
    parameter int RCD_TICKS = 1,
    parameter int CAS_TICKS = 2,
    localparam int ROW_W    = ADDR_W - PAGE_W,
    localparam int MUX_W    = (ROW_W > PAGE_W) ? ROW_W : PAGE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              req_write_i,
    input  logic              req_fetch_i,
    input  logic [7:0]        req_opcode_i,
    input  logic              vid_busy_i,
    input  logic              rfsh_busy_i,
    input  logic              irq_entry_i,
    output logic              ras_o,
    output logic              cas_o,
    output logic              we_o,
    output logic [MUX_W-1:0]  mem_addr_o,
    output logic              done_o,
    output logic              page_cycle_o
);
    import pcs_pkg::*;

    typedef struct packed {
        logic              busy;   // a cycle is in progress
        logic              page;   // the cycle in progress is a page cycle
        logic [PH_W-1:0]   ph;     // tick index inside the cycle
        logic              hold;   // row left open while idle
        logic              kill;   // a veto was seen during this cycle
        logic              wr;     // cycle is a write
        logic              ok;     // cycle may leave the row open for the next fetch
        logic [ADDR_W-1:0] addr;   // latched address
    } st_t;

    st_t st_d, st_q;

    logic seq_w, col_last_w;
    logic ras_w, cas_w, col_sel_w, done_w;
    logic veto, last, end_ok, hold_eff, start;

    pcs_predict #(
        .PAGE_W(PAGE_W)
    ) u_predict (
        .opcode_i  (req_opcode_i),
        .col_i     (req_addr_i[PAGE_W-1:0]),
        .seq_o     (seq_w),
        .col_last_o(col_last_w)
    );

    pcs_strobe #(
        .PRE_TICKS(PRE_TICKS),
        .RCD_TICKS(RCD_TICKS),
        .CAS_TICKS(CAS_TICKS)
    ) u_strobe (
        .page_i   (st_q.page),
        .ph_i     (st_q.ph),
        .ras_o    (ras_w),
        .cas_o    (cas_w),
        .col_sel_o(col_sel_w),
        .done_o   (done_w)
    );

    assign veto     = vid_busy_i | rfsh_busy_i | irq_entry_i;
    assign last     = st_q.busy & done_w;
    assign end_ok   = st_q.ok & ~st_q.kill & ~veto;
    assign hold_eff = last ? end_ok : st_q.hold;
    assign start    = req_valid_i & (~st_q.busy | last);

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.ph   = '0;
            st_d.page = req_fetch_i & ~req_write_i & hold_eff & ~veto;
            st_d.hold = 1'b0;
            st_d.kill = 1'b0;
            st_d.wr   = req_write_i;
            st_d.ok   = req_fetch_i & ~req_write_i & seq_w & ~col_last_w;
            st_d.addr = req_addr_i;
        end else if (st_q.busy) begin
            st_d.ph   = st_q.ph + 1'b1;
            st_d.kill = st_q.kill | veto;
            if (last) begin
                st_d.busy = 1'b0;
                st_d.page = 1'b0;
                st_d.ph   = '0;
                st_d.hold = end_ok;
            end
        end else begin
            st_d.hold = st_q.hold & ~veto;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ras_o        = st_q.busy ? ras_w : st_q.hold;
    assign cas_o        = st_q.busy & cas_w;
    assign we_o         = st_q.busy & st_q.wr;
    assign done_o       = last;
    assign page_cycle_o = st_q.busy & st_q.page;
    assign mem_addr_o   = (st_q.busy & col_sel_w) ? MUX_W'(st_q.addr[PAGE_W-1:0])
                                                  : MUX_W'(st_q.addr[ADDR_W-1:PAGE_W]);

endmodule

// File: rtl/page_cycle_seq_checks.sv
module page_cycle_seq_checks (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic ras,
    input logic cas,
    input logic we,
    input logic done,
    input logic page,
    input logic veto
);

    // R3, R9: a page cycle only runs on a row that was already open
    p_page_row_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        page |-> (ras && $past(ras)));

    // R2: the column strobe never appears without the row strobe
    p_cas_in_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cas |-> ras);

    // R4: page cycles are never writes
    p_page_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        page |-> !we);

    // R8: a veto while idle closes the row on the next tick
    p_idle_veto_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && veto) |=> !ras);

    // R2: the completion pulse lasts one tick
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: nothing but the row strobe is active while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cas && !we && !done && !page));

endmodule

bind page_cycle_seq page_cycle_seq_checks u_checks (
    .clk  (clk_i),
    .rst_n(rst_ni),
    .busy (st_q.busy),
    .ras  (ras_o),
    .cas  (cas_o),
    .we   (we_o),
    .done (done_o),
    .page (page_cycle_o),
    .veto (vid_busy_i | rfsh_busy_i | irq_entry_i)
);

// File: tb/page_cycle_seq_test.sv
module page_cycle_seq_test;

    localparam int PERIOD = 10;
    localparam int AW = 10;
    localparam int PW = 4;
    localparam int MW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          req_fetch = 1'b0;
    logic [7:0]    req_opcode = 8'hEA;
    logic          vid = 1'b0, rfsh = 1'b0, irq = 1'b0;
    logic          ras, cas, we, done, pagec;
    logic [MW-1:0] maddr;

    int checks = 0;
    int errors = 0;
    bit hold_m = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    page_cycle_seq #(.ADDR_W(AW), .PAGE_W(PW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
        .req_write_i(req_write), .req_fetch_i(req_fetch), .req_opcode_i(req_opcode),
        .vid_busy_i(vid), .rfsh_busy_i(rfsh), .irq_entry_i(irq),
        .ras_o(ras), .cas_o(cas), .we_o(we), .mem_addr_o(maddr),
        .done_o(done), .page_cycle_o(pagec)
    );

    function automatic bit seq_op(input logic [7:0] o);
        return !(o == 8'h00 || o == 8'h20 || o == 8'h40 || o == 8'h60 ||
                 o == 8'h4C || o == 8'h6C || o == 8'h7C || o == 8'h80 ||
                 o[4:0] == 5'b10000);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_veto(input int sel, input bit v);
        if (sel == 1) vid = v;
        if (sel == 2) rfsh = v;
        if (sel == 3) irq = v;
    endtask

    // Runs one cycle from a negedge and returns at the negedge where done is seen.
    // veto_at: -1 none, 0 in the acceptance tick, k>0 for one tick after tick k.
    task automatic run_cycle(input logic [AW-1:0] a, input bit wr, input bit fetch,
                             input logic [7:0] opc, input int vsel, input int veto_at,
                             input string req);
        bit            pg;
        int            len, n, bad_n;
        bit            ok;
        logic [MW-1:0] rowv, colv, aexp;
        pg   = fetch && !wr && hold_m && (veto_at != 0);
        len  = pg ? 4 : 5;
        rowv = MW'(a[AW-1:PW]);
        colv = MW'(a[PW-1:0]);
        req_addr = a; req_write = wr; req_fetch = fetch; req_opcode = opc;
        req_valid = 1'b1;
        if (veto_at == 0) set_veto(vsel, 1'b1);
        n = 0; ok = 1'b1; bad_n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
            set_veto(vsel, 1'b0);
            aexp = (pg || n >= 3) ? colv : rowv;
            if (ras   !== (pg ? 1'b1 : (n >= 2))) ok = 1'b0;
            if (cas   !== (pg ? (n == 2 || n == 3) : (n == 3 || n == 4))) ok = 1'b0;
            if (done  !== (n == len)) ok = 1'b0;
            if (we    !== wr) ok = 1'b0;
            if (pagec !== pg) ok = 1'b0;
            if (maddr !== aexp) ok = 1'b0;
            if (!ok && bad_n == 0) bad_n = n;
            if (n == veto_at && veto_at > 0) set_veto(vsel, 1'b1);
        end while (!done && n < 8);
        req_valid = 1'b0;
        check(ok && n == len, req, pg ? "page cycle length/shape (tick of first mismatch in actual)"
                                      : "full cycle length/shape (tick of first mismatch in actual)",
              ok ? n : bad_n, len);
        hold_m = fetch && !wr && seq_op(opc) && (a[PW-1:0] != '1) && !(veto_at > 0);
    endtask

    task automatic idle(input int k);
        repeat (k) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check({ras, cas, we, done, pagec} == 5'b0, "R1", "strobes in reset",
              int'({ras, cas, we, done, pagec}), 0);
        rst_n = 1'b1;
        idle(1);
        check({ras, cas, we, done, pagec} == 5'b0, "R1", "strobes after reset",
              int'({ras, cas, we, done, pagec}), 0);

        // R4, R10: write and data read use full cycles and release the row
        run_cycle(10'h123, 1'b1, 1'b0, 8'hEA, 0, -1, "R4 R10 write");
        idle(2);
        check(ras == 1'b0, "R4", "row after write", ras, 0);
        run_cycle(10'h124, 1'b0, 1'b0, 8'hEA, 0, -1, "R4 R11 data read");
        idle(1);
        check(ras == 1'b0, "R4", "row after data read", ras, 0);

        // R2, R3, R5, R11: a fetch chain turns into page cycles
        run_cycle(10'h040, 1'b0, 1'b1, 8'hEA, 0, -1, "R2 R11 first fetch");
        run_cycle(10'h041, 1'b0, 1'b1, 8'hEA, 0, -1, "R3 R5 second fetch");
        run_cycle(10'h042, 1'b0, 1'b1, 8'hEA, 0, -1, "R3 R5 third fetch");
        // R9: row stays open across idle ticks
        idle(3);
        check(ras == 1'b1, "R9", "row held while idle", ras, 1);
        run_cycle(10'h043, 1'b0, 1'b1, 8'hEA, 0, -1, "R9 page after gap");
        // R4: a write after open row is full and closes the row
        run_cycle(10'h050, 1'b1, 1'b0, 8'hEA, 0, -1, "R4 R10 write on open row");
        idle(1);
        check(ras == 1'b0, "R4", "row after write on open row", ras, 0);

        // R6: every opcode byte value
        for (int op = 0; op < 256; op++) begin
            run_cycle(10'h200, 1'b0, 1'b0, 8'hEA, 0, -1, "R4 data read before sweep");
            run_cycle(10'h300, 1'b0, 1'b1, 8'(op), 0, -1, "R6 fetch with swept opcode");
            run_cycle(10'h301, 1'b0, 1'b1, 8'hEA, 0, -1, "R6 R5 fetch after swept opcode");
        end

        // R7: every column position
        for (int c = 0; c < 16; c++) begin
            run_cycle(10'h200, 1'b0, 1'b0, 8'hEA, 0, -1, "R4 data read before column");
            run_cycle(AW'(10'h050 + c), 1'b0, 1'b1, 8'hEA, 0, -1, "R7 fetch on swept column");
            run_cycle(AW'(10'h051 + c), 1'b0, 1'b1, 8'hEA, 0, -1, "R7 following fetch");
        end

        // R8: each veto source in three positions
        for (int s = 1; s <= 3; s++) begin
            // idle veto
            run_cycle(10'h080, 1'b0, 1'b1, 8'hEA, 0, -1, "R8 open row");
            idle(1);
            check(ras == 1'b1, "R9", "row held before idle veto", ras, 1);
            set_veto(s, 1'b1);
            idle(1);
            set_veto(s, 1'b0);
            check(ras == 1'b0, "R8", "row after idle veto", ras, 0);
            hold_m = 1'b0;
            run_cycle(10'h081, 1'b0, 1'b1, 8'hEA, 0, -1, "R8 fetch after idle veto");
            // veto in the acceptance tick
            run_cycle(10'h082, 1'b0, 1'b1, 8'hEA, s, 0, "R8 veto at acceptance");
            run_cycle(10'h083, 1'b0, 1'b1, 8'hEA, 0, -1, "R8 fetch after accepted veto");
            // veto inside a page cycle
            run_cycle(10'h084, 1'b0, 1'b1, 8'hEA, s, 2, "R8 veto inside page cycle");
            run_cycle(10'h085, 1'b0, 1'b1, 8'hEA, 0, -1, "R8 fetch after cycle veto");
            run_cycle(10'h086, 1'b0, 1'b1, 8'hEA, 0, -1, "R5 fetch after recovery");
            run_cycle(10'h200, 1'b0, 1'b0, 8'hEA, 0, -1, "R4 close row");
        end

        idle(2);
        check({cas, we, done, pagec} == 4'b0, "R10", "idle strobes at end",
              int'({cas, we, done, pagec}), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule